// File: doc/BRIEF.md
# Flash In-System Programming Guard

This block sits between software and the on-chip flash controller. It holds one 8-bit control word. The word carries three update-enable bits, a boot-select bit, a sticky failure flag and a 3-bit program-time code. Every in-system programming command names a target region, an operation and a word address. The block checks each command against the enable bits and against the region where code is currently running. The boot-select bit gives that region: 1 means code runs from the loader, 0 means it runs from the application.

A command that breaks any rule is aborted. It raises the failure flag and reports completion on the next cycle. A legal program command opens a program pulse, and `busy` stays high for the whole pulse. The pulse length is set by the program-time code and scaled by a clocks-per-microsecond parameter. A legal erase command completes on the next cycle, because erase timing belongs to the flash array. The command port is valid/ready. `cmd_ready` is low while a pulse is running, and a command that is held during that time stays pending until the pulse ends. Register writes only change the word while `unlock` is high.

Top module: `flash_isp_guard`

## Requirements
- R1: The control word reads back on `reg_rdata` with this layout: bit 0 is boot-select (1 = loader), bit 1 is application-update enable, bit 2 is config-update enable, bit 3 is loader-update enable, bit 4 is the failure flag and bits 7:5 are the program-time code. Any reset clears bits 7:1.
- R2: A register write with `unlock` low changes no bit of the control word.
- R3: An unlocked write with a 1 in bit 4 clears the failure flag. An unlocked write with a 0 in bit 4 leaves the flag unchanged.
- R4: A command to the application region (region code 0) fails when boot-select is 0 and application-update enable is 0. When code runs from the loader, the application region may be updated.
- R5: A command to the loader region (region code 1) fails whenever boot-select is 1, whatever the enable bits hold.
- R6: With boot-select 0, a loader-region command fails unless loader-update enable is 1.
- R7: A command to the config region (region code 2) fails when config-update enable is 0.
- R8: A command fails when its address is not below the size of its region (defaults: 3072 application words, 1024 loader words, 2 config words). A command with region code 3 always fails.
- R9: A failing command sets the failure flag and starts no pulse: `busy` stays low, and `done` is high for exactly the cycle after the command is accepted.
- R10: A legal program command (`cmd_op` = 0) holds `busy` high for T × CLK_PER_US cycles. T is 40, 45, 50 or 55 µs for codes 0 to 3, and 20, 25, 30 or 35 µs for codes 4 to 7. `done` is high for the one cycle after `busy` falls.
- R11: `cmd_ready` is low exactly while `busy` is high. A command held during a pulse is not taken and has no effect.
- R12: On reset, boot-select loads the inverse of `cfg_boot` when `rst_cause` is 0 (power-on) or 1 (external). It keeps its value when `rst_cause` is 2 (CPU) or 3 (system).
- R13: A legal erase command (`cmd_op` = 1) starts no pulse. `done` is high for the cycle after the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rst_cause | input | 2 | Cause of the current reset: 0 power-on, 1 external, 2 CPU, 3 system |
| cfg_boot | input | 1 | Boot bit from configuration; its inverse reloads boot-select |
| unlock | input | 1 | High enables writes to the control word |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_region | input | 2 | Target region: 0 application, 1 loader, 2 config |
| cmd_op | input | 1 | 0 program, 1 erase |
| cmd_addr | input | ADDR_W | Word address within the target region |
| busy | output | 1 | Program pulse in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest case is the boot-select reload. It needs resets that arrive with different `rst_cause` values and a boot-select that software has already moved away from its reset value. The stimulus first writes boot-select to 1 through an unlocked write. It then applies CPU and system resets and shows the bit survives while the enables clear. Next it applies external and power-on resets with each level of `cfg_boot`. A second hard case is a command held while a pulse is running: an illegal command is kept valid through the middle of an 80-cycle pulse, and the bench confirms the failure flag is still clear after completion.

// File: rtl/fisp_pkg.sv
package fisp_pkg;
  typedef enum logic [1:0] {RG_APP = 2'd0, RG_LDR = 2'd1, RG_CFG = 2'd2, RG_NONE = 2'd3} region_e;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_e;
  localparam logic [1:0] RC_CPU = 2'd2;
  localparam logic [1:0] RC_SYS = 2'd3;
  localparam int FAIL_BIT = 4;

  // Pulse width in microseconds; upper half of the code space is the shorter set.
  function automatic int unsigned pulse_us(input logic [2:0] code);
    int unsigned base;
    base = code[2] ? 20 : 40;
    return base + 5 * int'(code[1:0]);
  endfunction
endpackage

// File: rtl/fisp_regs.sv
module fisp_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reload_ok,
  input  logic       cfg_boot,
  input  logic       unlock,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       fail_set,
  output logic [7:0] ctrl
);
  import fisp_pkg::*;
  logic [2:0] ptime_q;
  logic       ldr_en_q, cfg_en_q, app_en_q, fail_q, boot_q;
  logic       wr_ok;

  assign wr_ok = wr && unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptime_q  <= '0;
      ldr_en_q <= 1'b0;
      cfg_en_q <= 1'b0;
      app_en_q <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      if (wr_ok) begin
        ptime_q  <= wdata[7:5];
        ldr_en_q <= wdata[3];
        cfg_en_q <= wdata[2];
        app_en_q <= wdata[1];
      end
      if (fail_set)
        fail_q <= 1'b1;
      else if (wr_ok && wdata[FAIL_BIT])
        fail_q <= 1'b0;
    end
  end

  // Boot-select survives some reset causes, so it uses a conditional synchronous load.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (reload_ok) boot_q <= ~cfg_boot;
    end else if (wr_ok) begin
      boot_q <= wdata[0];
    end
  end

  assign ctrl = {ptime_q, fail_q, ldr_en_q, cfg_en_q, app_en_q, boot_q};
endmodule

// File: rtl/fisp_perm.sv
module fisp_perm #(
  parameter int ADDR_W    = 12,
  parameter int APP_WORDS = 3072,
  parameter int LDR_WORDS = 1024,
  parameter int CFG_WORDS = 2
) (
  input  logic [1:0]        region,
  input  logic [ADDR_W-1:0] addr,
  input  logic              run_ldr,
  input  logic              app_en,
  input  logic              ldr_en,
  input  logic              cfg_en,
  output logic              bad
);
  import fisp_pkg::*;
  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    case (region_e'(region))
      RG_APP:  bad = (!run_ldr && !app_en) || (a32 >= 32'(APP_WORDS));
      RG_LDR:  bad = run_ldr || !ldr_en || (a32 >= 32'(LDR_WORDS));
      RG_CFG:  bad = !cfg_en || (a32 >= 32'(CFG_WORDS));
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/fisp_timer.sv
module fisp_timer #(
  parameter int CLK_PER_US = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] code,
  output logic       busy,
  output logic       fin
);
  import fisp_pkg::*;
  localparam int MAXC = 55 * CLK_PER_US;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load;

  assign load = CW'(pulse_us(code) * CLK_PER_US - 1);
  assign fin  = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= load;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/flash_isp_guard.sv
module flash_isp_guard #(
  parameter int ADDR_W     = 12,
  parameter int APP_WORDS  = 3072,
  parameter int LDR_WORDS  = 1024,
  parameter int CFG_WORDS  = 2,
  parameter int CLK_PER_US = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rst_cause,
  input  logic              cfg_boot,
  input  logic              unlock,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_region,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              done
);
  import fisp_pkg::*;
  logic [7:0] ctrl;
  logic       cmd_bad, accept, start, fail_set, fin, reload_ok, done_q;

  assign reload_ok = (rst_cause != RC_CPU) && (rst_cause != RC_SYS);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign fail_set  = accept && cmd_bad;
  assign start     = accept && !cmd_bad && (op_e'(cmd_op) == OP_PROG);

  fisp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reload_ok(reload_ok), .cfg_boot(cfg_boot),
    .unlock(unlock), .wr(reg_wr), .wdata(reg_wdata), .fail_set(fail_set),
    .ctrl(ctrl)
  );

  fisp_perm #(
    .ADDR_W(ADDR_W), .APP_WORDS(APP_WORDS), .LDR_WORDS(LDR_WORDS), .CFG_WORDS(CFG_WORDS)
  ) u_perm (
    .region(cmd_region), .addr(cmd_addr), .run_ldr(ctrl[0]),
    .app_en(ctrl[1]), .ldr_en(ctrl[3]), .cfg_en(ctrl[2]), .bad(cmd_bad)
  );

  fisp_timer #(.CLK_PER_US(CLK_PER_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .code(ctrl[7:5]),
    .busy(busy), .fin(fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= (accept && (cmd_bad || (op_e'(cmd_op) == OP_ERASE))) || fin;
  end

  assign done      = done_q;
  assign reg_rdata = ctrl;
endmodule

// File: rtl/fisp_chk.sv
module fisp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       unlock,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       cmd_op,
  input logic       cmd_bad,
  input logic       busy,
  input logic       done
);
  p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !unlock && !(cmd_valid && cmd_ready)) |=> $stable(reg_rdata));

  p_zero_keeps_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && unlock && !reg_wdata[4] && reg_rdata[4]) |=> reg_rdata[4]);

  p_fail_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_bad) |=> (done && !busy && reg_rdata[4]));

  p_prog_starts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_bad && !cmd_op) |=> busy);

  p_no_take_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_erase_quick_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_bad && cmd_op) |=> (done && !busy));
endmodule

bind flash_isp_guard fisp_chk i_fisp_chk (
  .clk(clk), .rst_n(rst_n), .unlock(unlock), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bad(cmd_bad),
  .busy(busy), .done(done)
);

// File: tb/test_flash_isp_guard.sv
module test_flash_isp_guard;
  localparam int CLK_PERIOD = 10;
  localparam int CPU_US     = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rst_cause = 2'd0;
  logic        cfg_boot = 1'b1;
  logic        unlock = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_region = '0;
  logic        cmd_op = 1'b0;
  logic [11:0] cmd_addr = '0;
  logic        busy, done;

  int n_checks = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [7:0] sh = '0;

  flash_isp_guard #(.CLK_PER_US(CPU_US)) i_flash_isp_guard (
    .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause), .cfg_boot(cfg_boot),
    .unlock(unlock), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_region(cmd_region),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] cause, input logic cb);
    @(negedge clk);
    rst_cause = cause; cfg_boot = cb; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] d, input logic unl);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d; unlock = unl;
    @(negedge clk);
    reg_wr = 1'b0; unlock = 1'b0;
  endtask

  task automatic set_ctrl(input logic [7:0] d);
    sh = d & 8'hEF;
    wr_ctrl(sh, 1'b1);
  endtask

  task automatic send(input logic [1:0] rg, input logic op, input int addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_region = rg; cmd_op = op; cmd_addr = 12'(addr);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Non-pulse command: done next cycle, no busy, flag as expected; flag cleared after.
  task automatic quick_cmd(input string req, input logic [1:0] rg, input logic op,
                           input int addr, input logic exp_fail);
    send(rg, op, addr);
    check(req, int'(done), 1);
    check(req, int'(busy), 0);
    check(req, int'(reg_rdata[4]), int'(exp_fail));
    if (exp_fail) wr_ctrl(sh | 8'h10, 1'b1);
  endtask

  task automatic t_reset();
    do_reset(2'd0, 1'b1);
    check("R1 reset word", int'(reg_rdata), 0);
    check("R11 ready after reset", int'(cmd_ready), 1);
    check("R11 busy/done after reset", int'({busy, done}), 0);
  endtask

  task automatic t_lock();
    wr_ctrl(8'hEE, 1'b0);
    check("R2 locked write", int'(reg_rdata), 0);
    set_ctrl(8'hEE);
    check("R1 read back", int'(reg_rdata), 8'hEE);
  endtask

  task automatic t_w1c();
    send(2'd3, 1'b1, 0);
    check("R9 done", int'(done), 1);
    check("R9 no busy", int'(busy), 0);
    check("R9 flag", int'(reg_rdata[4]), 1);
    @(negedge clk);
    check("R9 done one cycle", int'(done), 0);
    wr_ctrl(8'hEE, 1'b1);
    check("R3 zero keeps flag", int'(reg_rdata[4]), 1);
    wr_ctrl(8'hFE, 1'b0);
    check("R2 locked clear ignored", int'(reg_rdata[4]), 1);
    wr_ctrl(8'hFE, 1'b1);
    check("R3 one clears flag", int'(reg_rdata[4]), 0);
  endtask

  task automatic t_app();
    set_ctrl(8'h00);
    quick_cmd("R4 app self locked", 2'd0, 1'b0, 0, 1'b1);
    set_ctrl(8'h01);
    quick_cmd("R4 app from loader", 2'd0, 1'b1, 0, 1'b0);
    set_ctrl(8'h02);
    quick_cmd("R4 app self enabled", 2'd0, 1'b1, 0, 1'b0);
  endtask

  task automatic t_ldr();
    set_ctrl(8'h0F);
    quick_cmd("R5 loader self", 2'd1, 1'b1, 0, 1'b1);
    set_ctrl(8'h06);
    quick_cmd("R6 loader disabled", 2'd1, 1'b1, 0, 1'b1);
    set_ctrl(8'h08);
    quick_cmd("R6 loader enabled", 2'd1, 1'b1, 0, 1'b0);
  endtask

  task automatic t_cfg();
    set_ctrl(8'h0A);
    quick_cmd("R7 config disabled", 2'd2, 1'b1, 0, 1'b1);
    set_ctrl(8'h04);
    quick_cmd("R7 config enabled", 2'd2, 1'b1, 1, 1'b0);
  endtask

  task automatic t_range();
    set_ctrl(8'h0E);
    quick_cmd("R8 app last", 2'd0, 1'b1, 3071, 1'b0);
    quick_cmd("R8 app over", 2'd0, 1'b1, 3072, 1'b1);
    quick_cmd("R8 loader last", 2'd1, 1'b1, 1023, 1'b0);
    quick_cmd("R8 loader over", 2'd1, 1'b1, 1024, 1'b1);
    quick_cmd("R8 config over", 2'd2, 1'b1, 2, 1'b1);
    quick_cmd("R8 region 3", 2'd3, 1'b1, 0, 1'b1);
  endtask

  task automatic t_time();
    for (int code = 0; code < 8; code++) begin
      int us, cnt;
      us = (code < 4) ? 40 + 5 * code : 20 + 5 * (code - 4);
      set_ctrl(8'((code << 5) | 2));
      send(2'd0, 1'b0, 5);
      cnt = 0;
      while (busy && cnt < 1000) begin
        cnt++;
        @(negedge clk);
      end
      check($sformatf("R10 pulse code %0d", code), cnt, us * CPU_US);
      check("R10 done after pulse", int'(done), 1);
      @(negedge clk);
      check("R11 done one cycle", int'(done), 0);
    end
  endtask

  task automatic t_bp();
    int cnt;
    set_ctrl(8'h82);
    send(2'd0, 1'b0, 0);
    check("R11 busy", int'(busy), 1);
    cmd_valid = 1'b1; cmd_region = 2'd3; cmd_op = 1'b1;
    for (int i = 0; i < 10; i++) begin
      check("R11 not ready while busy", int'(cmd_ready), 0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    cnt = 0;
    while (busy && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    check("R11 done at end", int'(done), 1);
    check("R11 held command ignored", int'(reg_rdata[4]), 0);
    check("R11 ready after pulse", int'(cmd_ready), 1);
  endtask

  task automatic t_erase();
    set_ctrl(8'h02);
    send(2'd0, 1'b1, 100);
    check("R13 erase done", int'(done), 1);
    check("R13 erase no busy", int'(busy), 0);
    @(negedge clk);
    check("R13 erase done one cycle", int'(done), 0);
  endtask

  task automatic t_boot();
    set_ctrl(8'h07);
    do_reset(2'd2, 1'b1);
    check("R12 CPU reset keeps boot", int'(reg_rdata), 1);
    do_reset(2'd3, 1'b1);
    check("R12 system reset keeps boot", int'(reg_rdata), 1);
    do_reset(2'd1, 1'b1);
    check("R12 external reset reloads", int'(reg_rdata), 0);
    do_reset(2'd0, 1'b0);
    check("R12 power-on reloads", int'(reg_rdata), 1);
  endtask

  initial begin
    t_reset();
    t_lock();
    t_w1c();
    t_app();
    t_ldr();
    t_cfg();
    t_range();
    t_time();
    t_bp();
    t_erase();
    t_boot();
    $display("%0d/%0d checks passed", n_checks - n_bad, n_checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
        $display("%0d/%0d checks passed", n_checks - n_bad, n_checks);
        $finish;
      end
    end
  end
endmodule